// File: doc/BRIEF.md
# Segment Relocation and Limit Checker

This block turns the effective addresses a processor issues into physical addresses. It does this with one base value and one limit value per segment. There are two segments. The program segment serves instruction fetches, which are addressed by the program counter. The data segment serves loads and stores. Each port checks its address against its own segment's limit and adds that segment's base to form the physical address. The two ports are translated at the same time in the same cycle. Each port has its own registered result: a physical address with a one-cycle valid strobe, or a one-cycle violation pulse.

The four relocation values can be changed only while the processor reports supervisor mode. A write attempted in user mode leaves every value as it was and produces a one-cycle privilege fault. After reset all four values are zero. Every access therefore faults until supervisor software programs the segments.

Top module: `seg_relocator`

## Requirements
- R1: A synchronous active-low reset clears all four relocation values and all outputs to zero. Until the values are programmed, every access with a zero limit raises a violation.
- R2: A fetch request presented at a clock edge yields, one cycle later, `fetch_pa_vld` high for one cycle and `fetch_pa` equal to the effective address plus the program base, taken modulo 2^PA_W.
- R3: A data request yields, one cycle later, `data_pa_vld` high for one cycle and `data_pa` equal to the effective address plus the data base, taken modulo 2^PA_W.
- R4: An access is legal only when its zero-extended effective address is strictly less than its segment's limit. An address equal to the limit is a violation.
- R5: An illegal access raises the port's violation output for one cycle, one cycle after the request, and raises no valid strobe. Valid and violation are never high together.
- R6: With `supervisor` high, `cfg_we` writes `cfg_wdata` into the value picked by `cfg_sel`: 0 program base, 1 program limit, 2 data base, 3 data limit. An access at the same edge still uses the old value, and the new value applies from the next edge on.
- R7: A write with `supervisor` low changes no value. It raises `priv_fault` for exactly one cycle, one cycle later.
- R8: The fetch and data ports are translated independently in the same cycle, each against its own segment.
- R9: A cycle without a request on a port produces neither a valid strobe nor a violation on that port one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_req | input | 1 | Instruction fetch request |
| fetch_ea | input | EA_W | Fetch effective address (program counter) |
| fetch_pa | output | PA_W | Registered fetch physical address |
| fetch_pa_vld | output | 1 | Fetch translation valid strobe |
| fetch_viol | output | 1 | Fetch limit violation pulse |
| data_req | input | 1 | Load/store request |
| data_ea | input | EA_W | Data effective address |
| data_pa | output | PA_W | Registered data physical address |
| data_pa_vld | output | 1 | Data translation valid strobe |
| data_viol | output | 1 | Data limit violation pulse |
| cfg_we | input | 1 | Relocation value write enable |
| cfg_sel | input | 2 | Value select (0..3, see R6) |
| cfg_wdata | input | PA_W | Value to write |
| supervisor | input | 1 | High while the processor is in supervisor mode |
| priv_fault | output | 1 | Pulse for a write attempted in user mode |

## Verification
Assertions check four things on every cycle. A port never shows valid and violation together. A port with no request stays quiet the next cycle, and a port with a request always answers the next cycle. A user-mode write leaves all four values stable and raises the privilege fault, while a supervisor write never raises it. The bench scenarios are the only place where the numbers are checked: the sums of address and base, the strict limit boundary at limit-1 and at the limit itself, the rule that a write is seen one edge after it is made, and the fact that the two segments do not interfere with each other.

// File: rtl/seg_reloc_pkg.sv
// Shared definitions for the segment relocator.
// Assumes exactly two segments and four relocation values.
package seg_reloc_pkg;

    localparam int NUM_SEG = 2;

    // Segment index used by the port generate loop.
    typedef enum logic [0:0] {
        SEG_PROG = 1'b0,
        SEG_DATA = 1'b1
    } seg_e;

    // Write-select code. The encoding is fixed by the register-write port.
    typedef enum logic [1:0] {
        SEL_PROG_BASE  = 2'd0,
        SEL_PROG_LIMIT = 2'd1,
        SEL_DATA_BASE  = 2'd2,
        SEL_DATA_LIMIT = 2'd3
    } val_sel_e;

endpackage

// File: rtl/reloc_regs.sv
// Holds the four relocation values (base and limit for two segments).
// Writes take effect only in supervisor mode. A user-mode write is dropped
// and yields a one-cycle privilege fault. Synchronous active-low reset.
module reloc_regs
    import seg_reloc_pkg::*;
#(
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [VAL_W-1:0] wr_data,
    input  logic             supervisor,
    output logic [VAL_W-1:0] prog_base,
    output logic [VAL_W-1:0] prog_limit,
    output logic [VAL_W-1:0] data_base,
    output logic [VAL_W-1:0] data_limit,
    output logic             priv_fault
);

    localparam int NUM_VAL = 4;

    logic [VAL_W-1:0] val_q [NUM_VAL];
    logic             legal_wr;
    logic             illegal_wr;

    // Classify the write attempt by processor mode.
    always_comb begin
        legal_wr   = wr_en && supervisor;
        illegal_wr = wr_en && !supervisor;
    end

    for (genvar i = 0; i < NUM_VAL; i++) begin : g_val
        // Each value loads only on a legal write that selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                val_q[i] <= '0;
            else if (legal_wr && (wr_sel == 2'(i)))
                val_q[i] <= wr_data;
        end
    end

    // One-cycle fault pulse for a write made in user mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            priv_fault <= 1'b0;
        else
            priv_fault <= illegal_wr;
    end

    // Map the storage onto named outputs.
    always_comb begin
        prog_base  = val_q[SEL_PROG_BASE];
        prog_limit = val_q[SEL_PROG_LIMIT];
        data_base  = val_q[SEL_DATA_BASE];
        data_limit = val_q[SEL_DATA_LIMIT];
    end

    AST_USER_WR_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !supervisor) |=> priv_fault); // R7
    AST_USER_WR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !supervisor) |=> ($stable(prog_base) && $stable(prog_limit)
                                    && $stable(data_base) && $stable(data_limit))); // R7
    AST_SUP_WR_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && supervisor) |=> !priv_fault); // R6
    AST_NO_WR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(prog_base) && $stable(data_limit))); // R6

endmodule

// File: rtl/seg_check.sv
// Translates one port: checks the effective address against a limit and
// adds a base. The result is registered: a valid strobe with the address,
// or a violation pulse. Assumes PA_W >= EA_W. The sum wraps modulo 2^PA_W.
module seg_check #(
    parameter int EA_W = 12,
    parameter int PA_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [EA_W-1:0] ea,
    input  logic [PA_W-1:0] base,
    input  logic [PA_W-1:0] limit,
    output logic [PA_W-1:0] pa,
    output logic            pa_vld,
    output logic            viol
);

    localparam int EXT_W = PA_W - EA_W;

    logic [PA_W-1:0] ea_ext;
    logic            in_range;
    logic [PA_W-1:0] sum;

    // Widen the address, compare it strictly below the limit, form the sum.
    always_comb begin
        ea_ext   = {{EXT_W{1'b0}}, ea};
        in_range = ea_ext < limit;
        sum      = ea_ext + base;
    end

    // Register the outcome. The address holds its last legal value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa     <= '0;
            pa_vld <= 1'b0;
            viol   <= 1'b0;
        end else begin
            pa_vld <= req && in_range;
            viol   <= req && !in_range;
            if (req && in_range)
                pa <= sum;
        end
    end

    AST_VLD_VIOL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pa_vld && viol)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!pa_vld && !viol)); // R9
    AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (pa_vld || viol)); // R5
    AST_ZERO_LIMIT_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req && limit == '0) |=> viol); // R1

endmodule

// File: rtl/seg_relocator.sv
// Top level: a fetch port and a data port, each translated by its own
// segment checker, plus the mode-guarded relocation value store.
// Both ports work in the same cycle and share no logic.
module seg_relocator
    import seg_reloc_pkg::*;
#(
    parameter int EA_W = 12,
    parameter int PA_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_req,
    input  logic [EA_W-1:0] fetch_ea,
    output logic [PA_W-1:0] fetch_pa,
    output logic            fetch_pa_vld,
    output logic            fetch_viol,
    input  logic            data_req,
    input  logic [EA_W-1:0] data_ea,
    output logic [PA_W-1:0] data_pa,
    output logic            data_pa_vld,
    output logic            data_viol,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    input  logic [PA_W-1:0] cfg_wdata,
    input  logic            supervisor,
    output logic            priv_fault
);

    logic [PA_W-1:0] prog_base, prog_limit, data_base, data_limit;

    logic            p_req   [NUM_SEG];
    logic [EA_W-1:0] p_ea    [NUM_SEG];
    logic [PA_W-1:0] p_base  [NUM_SEG];
    logic [PA_W-1:0] p_limit [NUM_SEG];
    logic [PA_W-1:0] p_pa    [NUM_SEG];
    logic            p_vld   [NUM_SEG];
    logic            p_viol  [NUM_SEG];

    reloc_regs #(.VAL_W(PA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we),
        .wr_sel     (cfg_sel),
        .wr_data    (cfg_wdata),
        .supervisor (supervisor),
        .prog_base  (prog_base),
        .prog_limit (prog_limit),
        .data_base  (data_base),
        .data_limit (data_limit),
        .priv_fault (priv_fault)
    );

    // Route each port and its segment values into the per-port arrays.
    always_comb begin
        p_req[SEG_PROG]   = fetch_req;
        p_ea[SEG_PROG]    = fetch_ea;
        p_base[SEG_PROG]  = prog_base;
        p_limit[SEG_PROG] = prog_limit;
        p_req[SEG_DATA]   = data_req;
        p_ea[SEG_DATA]    = data_ea;
        p_base[SEG_DATA]  = data_base;
        p_limit[SEG_DATA] = data_limit;
    end

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_port
        seg_check #(.EA_W(EA_W), .PA_W(PA_W)) u_chk (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (p_req[s]),
            .ea     (p_ea[s]),
            .base   (p_base[s]),
            .limit  (p_limit[s]),
            .pa     (p_pa[s]),
            .pa_vld (p_vld[s]),
            .viol   (p_viol[s])
        );
    end

    // Return the per-port results to the named outputs.
    always_comb begin
        fetch_pa     = p_pa[SEG_PROG];
        fetch_pa_vld = p_vld[SEG_PROG];
        fetch_viol   = p_viol[SEG_PROG];
        data_pa      = p_pa[SEG_DATA];
        data_pa_vld  = p_vld[SEG_DATA];
        data_viol    = p_viol[SEG_DATA];
    end

    AST_PORTS_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !data_req) |=> (!data_pa_vld && !data_viol)); // R8

endmodule

// File: tb/seg_relocator_test.sv
// Scoreboard bench: the driver pushes one expected item per cycle and the
// monitor pops it and compares it with the registered outputs.
module seg_relocator_test;

    localparam int EA_W = 12;
    localparam int PA_W = 16;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            fetch_req, data_req;
    logic [EA_W-1:0] fetch_ea, data_ea;
    logic [PA_W-1:0] fetch_pa, data_pa;
    logic            fetch_pa_vld, fetch_viol, data_pa_vld, data_viol;
    logic            cfg_we, supervisor, priv_fault;
    logic [1:0]      cfg_sel;
    logic [PA_W-1:0] cfg_wdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit running = 1'b0;

    typedef struct {
        bit              f_vld, f_viol, d_vld, d_viol, pf;
        logic [PA_W-1:0] f_pa, d_pa;
        string           tag;
    } exp_t;

    exp_t sb[$];

    logic [PA_W-1:0] m_val [4];

    always #5 clk = ~clk;

    seg_relocator #(.EA_W(EA_W), .PA_W(PA_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .fetch_req(fetch_req), .fetch_ea(fetch_ea), .fetch_pa(fetch_pa),
        .fetch_pa_vld(fetch_pa_vld), .fetch_viol(fetch_viol),
        .data_req(data_req), .data_ea(data_ea), .data_pa(data_pa),
        .data_pa_vld(data_pa_vld), .data_viol(data_viol),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .supervisor(supervisor), .priv_fault(priv_fault)
    );

    // Drive one cycle at the falling edge and push the expected outcome.
    task automatic step(input bit fr, input logic [EA_W-1:0] fea,
                        input bit dr, input logic [EA_W-1:0] dea,
                        input bit we, input logic [1:0] sel,
                        input logic [PA_W-1:0] wd, input bit sup,
                        input string tag);
        exp_t e;
        logic [PA_W-1:0] fx, dx;
        @(negedge clk);
        fetch_req = fr; fetch_ea = fea; data_req = dr; data_ea = dea;
        cfg_we = we; cfg_sel = sel; cfg_wdata = wd; supervisor = sup;
        fx = PA_W'(fea);
        dx = PA_W'(dea);
        e.tag    = tag;
        e.f_vld  = fr && (fx < m_val[1]);
        e.f_viol = fr && !(fx < m_val[1]);
        e.f_pa   = fx + m_val[0];
        e.d_vld  = dr && (dx < m_val[3]);
        e.d_viol = dr && !(dx < m_val[3]);
        e.d_pa   = dx + m_val[2];
        e.pf     = we && !sup;
        sb.push_back(e);
        if (we && sup) m_val[sel] = wd;
    endtask

    task automatic idle(input string tag);
        step(0, '0, 0, '0, 0, 2'd0, '0, 1'b1, tag);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [PA_W-1:0] wd, input string tag);
        step(0, '0, 0, '0, 1, sel, wd, 1'b1, tag);
    endtask

    // Monitor: pop and compare shortly after each rising edge.
    always @(posedge clk) begin
        #2;
        if (running && sb.size() > 0) begin
            exp_t e;
            bit ok;
            e = sb.pop_front();
            ok = (fetch_pa_vld == e.f_vld) && (fetch_viol == e.f_viol) &&
                 (data_pa_vld == e.d_vld) && (data_viol == e.d_viol) &&
                 (priv_fault == e.pf) &&
                 (!e.f_vld || fetch_pa == e.f_pa) &&
                 (!e.d_vld || data_pa == e.d_pa);
            n_cmp++;
            if (!ok) begin
                n_bad++;
                $display("FAIL %s: got fv=%0b fx=%0b fpa=%h dv=%0b dx=%0b dpa=%h pf=%0b exp fv=%0b fx=%0b fpa=%h dv=%0b dx=%0b dpa=%h pf=%0b",
                         e.tag, fetch_pa_vld, fetch_viol, fetch_pa, data_pa_vld, data_viol,
                         data_pa, priv_fault, e.f_vld, e.f_viol, e.f_pa, e.d_vld, e.d_viol,
                         e.d_pa, e.pf);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_val[i] = '0;
        rst_n = 1'b0; fetch_req = 0; data_req = 0; fetch_ea = '0; data_ea = '0;
        cfg_we = 0; cfg_sel = '0; cfg_wdata = '0; supervisor = 0;
        repeat (3) @(negedge clk);
        // R1: reset state of the outputs.
        n_cmp++;
        if (fetch_pa_vld || fetch_viol || data_pa_vld || data_viol || priv_fault
            || fetch_pa != '0 || data_pa != '0) begin
            n_bad++;
            $display("FAIL R1 reset: got fv=%0b fx=%0b dv=%0b dx=%0b pf=%0b exp all zero",
                     fetch_pa_vld, fetch_viol, data_pa_vld, data_viol, priv_fault);
        end
        rst_n = 1'b1;
        running = 1'b1;
        // R1: unprogrammed segments fault.
        step(1, 12'h005, 1, 12'h005, 0, 2'd0, '0, 1'b1, "R1 zero limits");
        idle("R9 idle");
        // R6: program all four values (no access, R9 quiet).
        wr(2'd0, 16'h1000, "R6 prog base");
        wr(2'd1, 16'h0100, "R6 prog limit");
        wr(2'd2, 16'h2000, "R6 data base");
        wr(2'd3, 16'h0080, "R6 data limit");
        // R2, R3: basic translation.
        step(1, 12'h010, 0, '0, 0, 2'd0, '0, 1'b1, "R2 fetch xlate");
        step(0, '0, 1, 12'h020, 0, 2'd0, '0, 1'b1, "R3 data xlate");
        // R4: boundaries.
        step(1, 12'h0FF, 1, 12'h07F, 0, 2'd0, '0, 1'b1, "R4 limit-1 legal");
        step(1, 12'h100, 1, 12'h080, 0, 2'd0, '0, 1'b1, "R4 R5 at limit");
        // R8: one port legal, the other not, same cycle.
        step(1, 12'h050, 1, 12'h0A0, 0, 2'd0, '0, 1'b1, "R8 mixed");
        step(1, 12'h300, 1, 12'h001, 0, 2'd0, '0, 1'b1, "R8 mixed rev");
        // R6: a write at the same edge as an access uses the old value.
        step(1, 12'h010, 0, '0, 1, 2'd0, 16'h3000, 1'b1, "R6 old value");
        step(1, 12'h010, 0, '0, 0, 2'd0, '0, 1'b1, "R6 new value");
        // R7: user-mode write is dropped and faults.
        step(0, '0, 0, '0, 1, 2'd1, 16'h0FFF, 1'b0, "R7 user write");
        step(1, 12'h200, 0, '0, 0, 2'd0, '0, 1'b1, "R7 limit kept");
        step(0, '0, 1, 12'h010, 1, 2'd2, 16'h7000, 1'b0, "R7 user write data");
        step(0, '0, 1, 12'h010, 0, 2'd0, '0, 1'b1, "R7 data base kept");
        // R3, R4: full range and wrap of the sum.
        wr(2'd3, 16'h1000, "R6 data limit full");
        step(0, '0, 1, 12'hFFF, 0, 2'd0, '0, 1'b1, "R4 top address");
        wr(2'd2, 16'hFF00, "R6 data base high");
        step(0, '0, 1, 12'h123, 0, 2'd0, '0, 1'b1, "R3 wrap");
        // R2, R3: back-to-back traffic on both ports.
        for (int k = 0; k < 8; k++)
            step(1, 12'(k * 37), 1, 12'(k * 511), 0, 2'd0, '0, 1'b1, "R2 R3 stream");
        idle("R9 idle end");
        idle("R9 idle end");
        repeat (3) @(negedge clk);
        running = 1'b0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule